// File: doc/BRIEF.md
# Programmable LCD Sync Timing Generator

This block produces the raster timing for an RGB TFT panel. It takes a set of programmed timing fields and generates four things from them: a pixel-rate enable, a pixel clock level, horizontal and vertical sync strobes, and a data-enable strobe. It also reports the coordinates of the current pixel inside the visible area. Horizontal fields count in groups of eight pixels, with an extra fine-tune term in steps of two pixels. Vertical fields count whole lines. Every field is stored as its value minus one.

The configuration inputs may change at any time. The block copies them into a shadow set only at the boundary between two frames, so every frame runs with one consistent timing. A display-enable input blanks the panel at once: data-enable goes inactive and both syncs rest at their inactive level, while the raster counters keep running. Each pixel lasts 1, 2, 4 or 8 system clocks, as chosen by a select code. All outputs for a pixel change together in the cycle marked by the pixel enable, and they hold until the next mark.

Top module: `lcd_sync_gen`

## Requirements
- R1: While reset is asserted: `pix_ce_o`, `pclk_o`, `de_o`, `x_o` and `y_o` are 0, and `hs_o` and `vs_o` are 1.
- R2: `pix_ce_o` is a one-cycle pulse. It repeats every 1, 2, 4 or 8 system clocks for `cfg_clk_sel` codes 0, 1, 2 and 3, and that period applies to the pixel whose outputs the pulse introduces.
- R3: Horizontal position h runs from 0 upward across each line. A pixel is in the active columns when h < (`cfg_h_width`+1)*8. Inside the active columns, `x_o` equals h.
- R4: A line has (`cfg_h_width`+1)*8 + (`cfg_h_blank`+1)*8 + ((`cfg_h_fine`>>1)+1)*2 + 2 pixels.
- R5: Horizontal sync is asserted for h in [A+(`cfg_h_sofs`+1)*8, A+(`cfg_h_sofs`+1)*8+(`cfg_h_slen`+1)*8), where A is the active width. The interval is cut off at the end of the line.
- R6: Line index v runs from 0 upward. The active lines are v < `cfg_v_height`+1. A frame has (`cfg_v_height`+1)+(`cfg_v_blank`+1) lines. Inside the active lines, `y_o` equals v.
- R7: Vertical sync is asserted on every pixel of lines v in [B+`cfg_v_sofs`+1, B+`cfg_v_sofs`+1+`cfg_v_slen`+1), where B is the active height. The interval is cut off at the end of the frame.
- R8: An asserted `hs_o` or `vs_o` equals its polarity bit (`cfg_h_pol`, `cfg_v_pol`; 1 = active high). An inactive sync is the inverse of that bit. `de_o` equals the active flag XOR `cfg_de_pol` (0 = active high).
- R9: Configuration is copied only at the pixel-enable step that wraps from the last pixel of a frame to pixel (0,0). Changes made during a frame take effect from the first pixel of the next frame.
- R10: When `disp_on` is 0 at a pixel step, that pixel shows data-enable and both syncs inactive.
- R11: `de_o`, `hs_o`, `vs_o`, `x_o` and `y_o` change only in cycles where `pix_ce_o` is 1.
- R12: `x_o` is 0 outside the active columns and `y_o` is 0 outside the active lines.
- R13: Let P be the pixel period and k the cycle index within a pixel, where k = 0 is the `pix_ce_o` cycle. For P > 1, `pclk_o` is low for k < P/2 and high for k >= P/2. For P = 1 it stays low. When `cfg_clk_inv` is 1 the level is inverted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| disp_on | input | 1 | 1 = display enabled, 0 = blank outputs |
| cfg_h_width | input | 7 | Active width in 8-pixel units, minus one |
| cfg_h_blank | input | 5 | Horizontal blank in 8-pixel units, minus one |
| cfg_h_fine | input | 4 | Blank fine tune (2-pixel steps of value>>1) |
| cfg_h_sofs | input | 5 | Hsync offset after active, 8-pixel units minus one |
| cfg_h_slen | input | 5 | Hsync length, 8-pixel units minus one |
| cfg_h_pol | input | 1 | Hsync polarity, 1 = active high |
| cfg_v_height | input | 9 | Active lines minus one |
| cfg_v_blank | input | 9 | Blank lines minus one |
| cfg_v_sofs | input | 9 | Vsync offset after active, lines minus one |
| cfg_v_slen | input | 7 | Vsync length, lines minus one |
| cfg_v_pol | input | 1 | Vsync polarity, 1 = active high |
| cfg_de_pol | input | 1 | Data-enable polarity, 1 = active low |
| cfg_clk_sel | input | 2 | Pixel period select: 1, 2, 4, 8 clocks |
| cfg_clk_inv | input | 1 | Invert pixel clock level |
| pix_ce_o | output | 1 | Pulse at the start of each pixel |
| pclk_o | output | 1 | Pixel clock level |
| de_o | output | 1 | Data enable |
| hs_o | output | 1 | Horizontal sync |
| vs_o | output | 1 | Vertical sync |
| x_o | output | 11 | Column inside active area |
| y_o | output | 10 | Line inside active area |

## Verification
Outputs are registered on the internal pixel tick. A pixel's strobes and coordinates therefore appear in the cycle where `pix_ce_o` is high, and they stay put for the P-1 cycles that follow. A shadow update takes effect on the first pulse after the wrap pulse. The bench samples on falling edges and copies the configuration and `disp_on` at every rising edge. On each `pix_ce_o` it predicts the pixel from the inputs it copied at the rising edge just before, and refreshes its model shadow only when the model passes the last pixel of a frame. Between pulses it checks that the outputs hold, and it checks the pixel clock level against the cycle index within the pixel.

// File: rtl/lcd_sync_pkg.sv
package lcd_sync_pkg;

  localparam int HACT_W  = 7;
  localparam int HBLK_W  = 5;
  localparam int HFINE_W = 4;
  localparam int HSOFS_W = 5;
  localparam int HSLEN_W = 5;
  localparam int VFLD_W  = 9;
  localparam int VSLEN_W = 7;
  localparam int SEL_W   = 2;

  typedef struct packed {
    logic [HACT_W-1:0]  h_width;
    logic [HBLK_W-1:0]  h_blank;
    logic [HFINE_W-1:0] h_fine;
    logic [HSOFS_W-1:0] h_sofs;
    logic [HSLEN_W-1:0] h_slen;
    logic               h_pol;
    logic [VFLD_W-1:0]  v_height;
    logic [VFLD_W-1:0]  v_blank;
    logic [VFLD_W-1:0]  v_sofs;
    logic [VSLEN_W-1:0] v_slen;
    logic               v_pol;
    logic               de_pol;
    logic [SEL_W-1:0]   clk_sel;
    logic               clk_inv;
  } lcd_cfg_t;

endpackage

// File: rtl/lcd_pix_div.sv
module lcd_pix_div #(
  parameter int SEL_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [SEL_W-1:0] sel,
  input  logic             inv,
  output logic             tick,
  output logic             pclk
);

  localparam int CNT_W = (1 << SEL_W) - 1;

  logic [CNT_W:0]   period;
  logic [CNT_W-1:0] per_m1;
  logic [CNT_W-1:0] per_half;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] half_q, half_d;
  logic             inv_q, inv_d;

  assign period   = (CNT_W+1)'(1) << sel;
  assign per_m1   = CNT_W'(period - 1'b1);
  assign per_half = CNT_W'(period >> 1);
  assign tick     = run && (cnt_q == '0);
  assign pclk     = (cnt_q < half_q) ^ inv_q;

  always_comb begin
    cnt_d  = cnt_q;
    half_d = half_q;
    inv_d  = inv_q;
    if (tick) begin
      cnt_d  = per_m1;
      half_d = per_half;
      inv_d  = inv;
    end else if (cnt_q != '0) begin
      cnt_d  = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      half_q <= '0;
      inv_q  <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      half_q <= half_d;
      inv_q  <= inv_d;
    end
  end

endmodule

// File: rtl/lcd_axis_cnt.sv
module lcd_axis_cnt #(
  parameter int CW = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv,
  input  logic [CW:0]   act_len,
  input  logic [CW:0]   blank_len,
  input  logic [CW:0]   sync_ofs,
  input  logic [CW:0]   sync_len,
  output logic [CW-1:0] pos,
  output logic          at_end,
  output logic          in_act,
  output logic          in_sync
);

  localparam int SW = CW + 2;

  logic [SW-1:0] pos_w, total_m1, s_beg, s_end;
  logic [CW-1:0] pos_d;

  assign pos_w    = SW'(pos);
  assign total_m1 = SW'(act_len) + SW'(blank_len) - SW'(1);
  assign s_beg    = SW'(act_len) + SW'(sync_ofs);
  assign s_end    = s_beg + SW'(sync_len);
  assign at_end   = (pos_w == total_m1);
  assign in_act   = (pos_w < SW'(act_len));
  assign in_sync  = (pos_w >= s_beg) && (pos_w < s_end);

  always_comb begin
    pos_d = pos;
    if (adv) pos_d = at_end ? '0 : pos + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pos <= '0;
    else        pos <= pos_d;
  end

endmodule

// File: rtl/lcd_sync_gen.sv
module lcd_sync_gen
  import lcd_sync_pkg::*;
#(
  parameter int H_CW = 11,
  parameter int V_CW = 10
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               disp_on,
  input  logic [HACT_W-1:0]  cfg_h_width,
  input  logic [HBLK_W-1:0]  cfg_h_blank,
  input  logic [HFINE_W-1:0] cfg_h_fine,
  input  logic [HSOFS_W-1:0] cfg_h_sofs,
  input  logic [HSLEN_W-1:0] cfg_h_slen,
  input  logic               cfg_h_pol,
  input  logic [VFLD_W-1:0]  cfg_v_height,
  input  logic [VFLD_W-1:0]  cfg_v_blank,
  input  logic [VFLD_W-1:0]  cfg_v_sofs,
  input  logic [VSLEN_W-1:0] cfg_v_slen,
  input  logic               cfg_v_pol,
  input  logic               cfg_de_pol,
  input  logic [SEL_W-1:0]   cfg_clk_sel,
  input  logic               cfg_clk_inv,
  output logic               pix_ce_o,
  output logic               pclk_o,
  output logic               de_o,
  output logic               hs_o,
  output logic               vs_o,
  output logic [H_CW-1:0]    x_o,
  output logic [V_CW-1:0]    y_o
);

  localparam int HL = H_CW + 1;
  localparam int VL = V_CW + 1;

  lcd_cfg_t cfg_in, sh_q, sh_d;
  logic     prim_q, prim_d;
  logic     tick;

  logic [HL-1:0]   h_act_len, h_blank_len, h_sofs_len, h_slen_len;
  logic [VL-1:0]   v_act_len, v_blank_len, v_sofs_len, v_slen_len;
  logic [H_CW-1:0] h_pos;
  logic [V_CW-1:0] v_pos;
  logic            h_end, h_in_act, h_in_sync;
  logic            v_end, v_in_act, v_in_sync;

  logic            pce_q, pce_d;
  logic            de_q, de_d, hs_q, hs_d, vs_q, vs_d;
  logic            hp_q, hp_d, vp_q, vp_d, dp_q, dp_d;
  logic [H_CW-1:0] x_q, x_d;
  logic [V_CW-1:0] y_q, y_d;

  assign cfg_in = '{h_width: cfg_h_width, h_blank: cfg_h_blank, h_fine: cfg_h_fine,
                    h_sofs: cfg_h_sofs, h_slen: cfg_h_slen, h_pol: cfg_h_pol,
                    v_height: cfg_v_height, v_blank: cfg_v_blank, v_sofs: cfg_v_sofs,
                    v_slen: cfg_v_slen, v_pol: cfg_v_pol, de_pol: cfg_de_pol,
                    clk_sel: cfg_clk_sel, clk_inv: cfg_clk_inv};

  // lengths in pixels / lines, decoded from the shadow set
  always_comb begin
    h_act_len   = HL'((int'(sh_q.h_width) + 1) * 8);
    h_blank_len = HL'((int'(sh_q.h_blank) + 1) * 8 + ((int'(sh_q.h_fine) >> 1) + 1) * 2 + 2);
    h_sofs_len  = HL'((int'(sh_q.h_sofs) + 1) * 8);
    h_slen_len  = HL'((int'(sh_q.h_slen) + 1) * 8);
    v_act_len   = VL'(int'(sh_q.v_height) + 1);
    v_blank_len = VL'(int'(sh_q.v_blank) + 1);
    v_sofs_len  = VL'(int'(sh_q.v_sofs) + 1);
    v_slen_len  = VL'(int'(sh_q.v_slen) + 1);
  end

  lcd_pix_div #(.SEL_W(SEL_W)) u_div (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (prim_q),
    .sel  (sh_q.clk_sel),
    .inv  (sh_q.clk_inv),
    .tick (tick),
    .pclk (pclk_o)
  );

  lcd_axis_cnt #(.CW(H_CW)) u_hcnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .adv      (tick),
    .act_len  (h_act_len),
    .blank_len(h_blank_len),
    .sync_ofs (h_sofs_len),
    .sync_len (h_slen_len),
    .pos      (h_pos),
    .at_end   (h_end),
    .in_act   (h_in_act),
    .in_sync  (h_in_sync)
  );

  lcd_axis_cnt #(.CW(V_CW)) u_vcnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .adv      (tick && h_end),
    .act_len  (v_act_len),
    .blank_len(v_blank_len),
    .sync_ofs (v_sofs_len),
    .sync_len (v_slen_len),
    .pos      (v_pos),
    .at_end   (v_end),
    .in_act   (v_in_act),
    .in_sync  (v_in_sync)
  );

  always_comb begin
    prim_d = 1'b1;
    sh_d   = sh_q;
    if (!prim_q || (tick && h_end && v_end)) sh_d = cfg_in;

    pce_d = tick;
    de_d  = de_q;
    hs_d  = hs_q;
    vs_d  = vs_q;
    hp_d  = hp_q;
    vp_d  = vp_q;
    dp_d  = dp_q;
    x_d   = x_q;
    y_d   = y_q;
    if (tick) begin
      de_d = disp_on && h_in_act && v_in_act;
      hs_d = disp_on && h_in_sync;
      vs_d = disp_on && v_in_sync;
      hp_d = sh_q.h_pol;
      vp_d = sh_q.v_pol;
      dp_d = sh_q.de_pol;
      x_d  = h_in_act ? h_pos : '0;
      y_d  = v_in_act ? v_pos : '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prim_q <= 1'b0;
      sh_q   <= '0;
      pce_q  <= 1'b0;
      de_q   <= 1'b0;
      hs_q   <= 1'b0;
      vs_q   <= 1'b0;
      hp_q   <= 1'b0;
      vp_q   <= 1'b0;
      dp_q   <= 1'b0;
      x_q    <= '0;
      y_q    <= '0;
    end else begin
      prim_q <= prim_d;
      sh_q   <= sh_d;
      pce_q  <= pce_d;
      de_q   <= de_d;
      hs_q   <= hs_d;
      vs_q   <= vs_d;
      hp_q   <= hp_d;
      vp_q   <= vp_d;
      dp_q   <= dp_d;
      x_q    <= x_d;
      y_q    <= y_d;
    end
  end

  assign pix_ce_o = pce_q;
  assign de_o     = de_q ^ dp_q;
  assign hs_o     = ~(hs_q ^ hp_q);
  assign vs_o     = ~(vs_q ^ vp_q);
  assign x_o      = x_q;
  assign y_o      = y_q;

endmodule

// File: rtl/lcd_sync_gen_chk.sv
module lcd_sync_gen_chk #(
  parameter int H_CW = 11,
  parameter int V_CW = 10
) (
  input logic            clk,
  input logic            rst_n,
  input logic            disp_on,
  input logic            pix_ce_o,
  input logic [H_CW-1:0] x_o,
  input logic [V_CW-1:0] y_o,
  input logic            de_r,
  input logic            hs_r,
  input logic            vs_r
);

  logic [H_CW-1:0] prev_x;
  logic            prev_de;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_x  <= '0;
      prev_de <= 1'b0;
    end else if (pix_ce_o) begin
      prev_x  <= x_o;
      prev_de <= de_r;
    end
  end

  // R11
  hold_between_ce_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_ce_o |-> ($stable(x_o) && $stable(y_o) && $stable(de_r) && $stable(hs_r) && $stable(vs_r)));

  // R3
  x_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_ce_o && de_r && prev_de && (x_o != '0)) |-> (x_o == prev_x + 1'b1));

  // R10
  blank_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_ce_o && !$past(disp_on)) |-> (!de_r && !hs_r && !vs_r));

  // R5
  hsync_in_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hs_r |-> !de_r);

  // R7
  vsync_in_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vs_r |-> !de_r);

endmodule

bind lcd_sync_gen lcd_sync_gen_chk #(.H_CW(H_CW), .V_CW(V_CW)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .disp_on (disp_on),
  .pix_ce_o(pix_ce_o),
  .x_o     (x_o),
  .y_o     (y_o),
  .de_r    (de_q),
  .hs_r    (hs_q),
  .vs_r    (vs_q)
);

// File: tb/lcd_sync_gen_bench.sv
module lcd_sync_gen_bench;
  import lcd_sync_pkg::*;

  localparam int H_CW = 11;
  localparam int V_CW = 10;

  logic clk = 1'b0;
  logic rst_n;
  logic disp_on;
  lcd_cfg_t cfg;

  logic pix_ce_o, pclk_o, de_o, hs_o, vs_o;
  logic [H_CW-1:0] x_o;
  logic [V_CW-1:0] y_o;

  always #10 clk = ~clk;

  lcd_sync_gen #(.H_CW(H_CW), .V_CW(V_CW)) u_lcd_sync_gen (
    .clk(clk), .rst_n(rst_n), .disp_on(disp_on),
    .cfg_h_width(cfg.h_width), .cfg_h_blank(cfg.h_blank), .cfg_h_fine(cfg.h_fine),
    .cfg_h_sofs(cfg.h_sofs), .cfg_h_slen(cfg.h_slen), .cfg_h_pol(cfg.h_pol),
    .cfg_v_height(cfg.v_height), .cfg_v_blank(cfg.v_blank), .cfg_v_sofs(cfg.v_sofs),
    .cfg_v_slen(cfg.v_slen), .cfg_v_pol(cfg.v_pol), .cfg_de_pol(cfg.de_pol),
    .cfg_clk_sel(cfg.clk_sel), .cfg_clk_inv(cfg.clk_inv),
    .pix_ce_o(pix_ce_o), .pclk_o(pclk_o), .de_o(de_o), .hs_o(hs_o), .vs_o(vs_o),
    .x_o(x_o), .y_o(y_o)
  );

  int n_chk = 0;
  int n_fail = 0;

  task automatic chk(input string tag, input int act, input int expv);
    n_chk++;
    if (act != expv) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  // expected timing computed from the requirement formulas
  function automatic int f_hact(lcd_cfg_t c);  return (int'(c.h_width) + 1) * 8; endfunction
  function automatic int f_htot(lcd_cfg_t c);
    return f_hact(c) + (int'(c.h_blank) + 1) * 8 + ((int'(c.h_fine) >> 1) + 1) * 2 + 2;
  endfunction
  function automatic int f_hs0(lcd_cfg_t c);   return f_hact(c) + (int'(c.h_sofs) + 1) * 8; endfunction
  function automatic int f_hs1(lcd_cfg_t c);   return f_hs0(c) + (int'(c.h_slen) + 1) * 8; endfunction
  function automatic int f_vact(lcd_cfg_t c);  return int'(c.v_height) + 1; endfunction
  function automatic int f_vtot(lcd_cfg_t c);  return f_vact(c) + int'(c.v_blank) + 1; endfunction
  function automatic int f_vs0(lcd_cfg_t c);   return f_vact(c) + int'(c.v_sofs) + 1; endfunction
  function automatic int f_vs1(lcd_cfg_t c);   return f_vs0(c) + int'(c.v_slen) + 1; endfunction

  typedef struct {
    int de; int hs; int vs; int x; int y;
  } exp_t;

  exp_t sb_q[$];

  lcd_cfg_t cfg_snap, m_sh;
  logic     disp_snap;
  always @(posedge clk) begin
    cfg_snap  <= cfg;
    disp_snap <= disp_on;
  end

  int  m_h = 0, m_v = 0, frames = 0, k = 0, cur_p = 1;
  bit  cur_inv = 1'b0, have_prev = 1'b0, mon_en = 1'b0;
  exp_t last;

  function automatic int exp_pclk(int kk);
    return int'(((cur_p > 1) && (kk >= cur_p / 2)) ^ cur_inv);
  endfunction

  // driver side of the scoreboard: push the prediction for the next pixel
  task automatic push_expect();
    exp_t e;
    bit a_h, a_v, s_h, s_v;
    a_h = m_h < f_hact(m_sh);
    a_v = m_v < f_vact(m_sh);
    s_h = (m_h >= f_hs0(m_sh)) && (m_h < f_hs1(m_sh));
    s_v = (m_v >= f_vs0(m_sh)) && (m_v < f_vs1(m_sh));
    e.de = int'((disp_snap && a_h && a_v) ^ m_sh.de_pol);
    e.hs = int'((disp_snap && s_h) ? m_sh.h_pol : !m_sh.h_pol);
    e.vs = int'((disp_snap && s_v) ? m_sh.v_pol : !m_sh.v_pol);
    e.x  = a_h ? m_h : 0;
    e.y  = a_v ? m_v : 0;
    sb_q.push_back(e);
  endtask

  // monitor: pops and compares on each pixel pulse, checks holds in between
  always @(negedge clk) begin
    if (mon_en) begin
      if (pix_ce_o) begin
        exp_t e;
        if (have_prev) chk("R2 pixel period", k + 1, cur_p);
        push_expect();
        e = sb_q.pop_front();
        chk("R3 R6 R8 R9 R10 de_o", int'(de_o), e.de);
        chk("R4 R5 R8 R10 hs_o", int'(hs_o), e.hs);
        chk("R7 R8 R10 vs_o", int'(vs_o), e.vs);
        chk("R3 R12 x_o", int'(x_o), e.x);
        chk("R6 R12 y_o", int'(y_o), e.y);
        cur_p   = 1 << m_sh.clk_sel;
        cur_inv = m_sh.clk_inv;
        k = 0;
        chk("R13 pclk_o", int'(pclk_o), exp_pclk(k));
        last = e;
        have_prev = 1'b1;
        if (m_h == f_htot(m_sh) - 1) begin
          m_h = 0;
          if (m_v == f_vtot(m_sh) - 1) begin
            m_v = 0;
            m_sh = cfg_snap;   // R9: new settings from the next frame on
            frames++;
          end else begin
            m_v++;
          end
        end else begin
          m_h++;
        end
      end else if (have_prev) begin
        k++;
        chk("R11 de_o hold", int'(de_o), last.de);
        chk("R11 hs_o hold", int'(hs_o), last.hs);
        chk("R11 vs_o hold", int'(vs_o), last.vs);
        chk("R11 x_o hold", int'(x_o), last.x);
        chk("R11 y_o hold", int'(y_o), last.y);
        chk("R13 pclk_o", int'(pclk_o), exp_pclk(k));
      end
    end
  end

  task automatic set_cfg(input int hw, input int hb, input int hf, input int ho, input int hl,
                         input int vh, input int vb, input int vo, input int vl,
                         input bit hp, input bit vp, input bit dp, input int sel, input bit inv);
    cfg.h_width  = HACT_W'(hw);
    cfg.h_blank  = HBLK_W'(hb);
    cfg.h_fine   = HFINE_W'(hf);
    cfg.h_sofs   = HSOFS_W'(ho);
    cfg.h_slen   = HSLEN_W'(hl);
    cfg.v_height = VFLD_W'(vh);
    cfg.v_blank  = VFLD_W'(vb);
    cfg.v_sofs   = VFLD_W'(vo);
    cfg.v_slen   = VSLEN_W'(vl);
    cfg.h_pol    = hp;
    cfg.v_pol    = vp;
    cfg.de_pol   = dp;
    cfg.clk_sel  = SEL_W'(sel);
    cfg.clk_inv  = inv;
  endtask

  task automatic wait_frames(input int n);
    int target;
    target = frames + n;
    while (frames < target) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", frames, 0);
    finish_run();
  end

  initial begin
    rst_n   = 1'b0;
    disp_on = 1'b1;
    // 20-pixel lines (8 active), hsync 16..23 cut at 20; 7 lines (4 active), vsync line 5
    set_cfg(0, 0, 0, 0, 0, 3, 2, 0, 0, 1'b0, 1'b0, 1'b0, 0, 1'b0);
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 pix_ce_o", int'(pix_ce_o), 0);
    chk("R1 pclk_o", int'(pclk_o), 0);
    chk("R1 de_o", int'(de_o), 0);
    chk("R1 hs_o", int'(hs_o), 1);
    chk("R1 vs_o", int'(vs_o), 1);
    chk("R1 x_o", int'(x_o), 0);
    chk("R1 y_o", int'(y_o), 0);
    m_sh = cfg;
    rst_n  = 1'b1;
    mon_en = 1'b1;
    wait_frames(2);

    // R9: change in mid-frame; period 2 inverted, all polarities flipped, fine tune 5
    repeat (37) @(negedge clk);
    set_cfg(1, 1, 5, 0, 1, 2, 3, 1, 1, 1'b1, 1'b1, 1'b1, 1, 1'b1);
    wait_frames(3);

    // period 8, long vsync cut at frame end, then a display-off window (R10)
    set_cfg(2, 0, 15, 1, 0, 1, 1, 0, 5, 1'b0, 1'b1, 1'b0, 3, 1'b0);
    wait_frames(2);
    repeat (61) @(negedge clk);
    disp_on = 1'b0;
    repeat (300) @(negedge clk);
    disp_on = 1'b1;
    wait_frames(2);

    // period 4 inverted
    set_cfg(0, 2, 2, 1, 2, 2, 4, 0, 1, 1'b1, 1'b0, 1'b1, 2, 1'b1);
    wait_frames(3);
    finish_run();
  end

endmodule